// File: doc/BRIEF.md
# Signed Complex Matrix-Vector Multiplier on a Nonnegative-Operand Engine

This block computes y = A·b for a complex M×N matrix A and a complex N-element vector b. Every element is a 9-bit two's-complement fixed-point value, which gives 8 magnitude bits and a sign. The block is built around a multiply-accumulate engine that takes only nonnegative left-hand operands. Each complex product is split into four real sub-products. Each left-hand matrix tile (the real part or the imaginary part of A) is lifted by the magnitude of its most negative element, so the engine never sees a negative left value. A correction term, formed by multiplying an all-ones matrix by the negated right-hand vector and scaled by that same magnitude, cancels the lift.

Operands arrive over one valid/ready stream. The matrix comes first, row-major, one complex element per beat. The vector follows, one element per beat. The four real passes then run one multiply-accumulate per cycle. When every pass has finished, the M complex results leave over a valid/ready output stream, row 0 first.

Top module: `cplx_offset_mvm`

## Requirements
- R1: The input stream takes exactly M·N matrix beats (row r, column c at beat r·N+c) and then N vector beats (element c at beat M·N+c). in_ready is high only while loading, and in_ready and out_valid are never high together.
- R2: out_re for row r equals the exact sum over c of Are[r][c]·bre[c] − Aim[r][c]·bim[c].
- R3: out_im for row r equals the exact sum over c of Are[r][c]·bim[c] + Aim[r][c]·bre[c].
- R4: The left operand given to the engine is never negative. This holds for every input, including tiles whose minimum is −256.
- R5: Results stay exact at the range limits, with every element at −256 or at 255, and no intermediate sum wraps.
- R6: When a tile has no negative element, its lift and its correction are zero, and the result is still exact.
- R7: The M results leave in row order. While out_valid is high and out_ready is low, out_valid stays high and both outputs hold.
- R8: The passes run in the order real·real, imag·imag, real·imag, imag·real. out_valid first rises exactly 4·M·N clock edges after the edge that accepts the last vector beat.
- R9: After reset, in_ready is high and out_valid is low. After the last result is taken, the block is ready for a new load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block accepts an input beat |
| in_re | input | W+1 | Real part of operand element, signed |
| in_im | input | W+1 | Imaginary part of operand element, signed |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Consumer takes the result beat |
| out_re | output | AW+1 | Real part of result row, signed |
| out_im | output | AW+1 | Imaginary part of result row, signed |

## Verification
The bench targets three kinds of error:
- **Lift error.** All-negative tiles at −256 make the lift as large as it gets. A design that takes the lift from the wrong tile, or drops the correction term, returns values shifted by the lift times the sum of the vector.
- **Zero-lift case.** All-positive tiles at 255 check that a zero lift adds nothing. The same operands also check that the accumulator does not wrap, which would show as a sign flip.
- **Ordering and backpressure.** The bench measures the latency exactly and stalls the output at random. A mixed-up pass order exchanges or negates the imaginary-part terms. Dropped backpressure loses result rows or changes them while they are held.

// File: rtl/cplx_offset_mvm.sv
module cplx_offset_mvm #(
  parameter int M = 4,
  parameter int N = 4,
  parameter int W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [W:0]    in_re,
  input  logic signed [W:0]    in_im,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [2*(W+1)+$clog2(N)+2:0] out_re,
  output logic signed [2*(W+1)+$clog2(N)+2:0] out_im
);
  localparam int DW = W + 1;
  localparam int AW = 2*DW + $clog2(N) + 2;
  localparam int MN = M * N;
  localparam int IW = $clog2(MN + N + 1);
  localparam int DEPTH = 2**IW;
  localparam logic [IW-1:0] LAST_LD  = IW'(MN + N - 1);
  localparam logic [IW-1:0] LAST_COL = IW'(N - 1);
  localparam logic [IW-1:0] LAST_ROW = IW'(M - 1);

  typedef enum logic [1:0] {S_LOAD, S_RUN, S_SEND} state_t;

  function automatic logic signed [AW-1:0] sx(input logic signed [DW-1:0] v);
    return {{(AW-DW){v[DW-1]}}, v};
  endfunction

  state_t state;
  logic [IW-1:0] ld_idx, row, col, orow;
  logic [1:0] pass;
  logic signed [DW-1:0] mem_re [DEPTH];
  logic signed [DW-1:0] mem_im [DEPTH];
  logic signed [DW-1:0] min_re, min_im;
  logic signed [AW-1:0] acc_main, acc_corr;
  logic signed [AW-1:0] part [4][DEPTH];

  // pass 0: re*re, 1: im*im, 2: re*im, 3: im*re
  wire left_im  = pass[0];
  wire right_im = pass[0] ^ pass[1];
  wire [IW-1:0] l_addr = IW'(int'(row) * N + int'(col));
  wire [IW-1:0] r_addr = IW'(MN + int'(col));

  logic signed [AW-1:0] off_re, off_im, off, lhs, rhs, main_n, corr_n;
  assign off_re = (min_re < 0) ? -sx(min_re) : '0;
  assign off_im = (min_im < 0) ? -sx(min_im) : '0;
  assign off    = left_im ? off_im : off_re;
  assign lhs    = sx(left_im ? mem_im[l_addr] : mem_re[l_addr]) + off;
  assign rhs    = sx(right_im ? mem_im[r_addr] : mem_re[r_addr]);
  assign main_n = ((col == '0) ? '0 : acc_main) + lhs * rhs;
  assign corr_n = ((col == '0) ? '0 : acc_corr) + off * (-rhs);

  assign in_ready  = (state == S_LOAD);
  assign out_valid = (state == S_SEND);
  assign out_re = {part[0][orow][AW-1], part[0][orow]} - {part[1][orow][AW-1], part[1][orow]};
  assign out_im = {part[2][orow][AW-1], part[2][orow]} + {part[3][orow][AW-1], part[3][orow]};

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      mem_re[ld_idx] <= in_re;
      mem_im[ld_idx] <= in_im;
    end
    if (state == S_RUN && col == LAST_COL)
      part[pass][row] <= main_n + corr_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_LOAD;
      ld_idx <= '0; row <= '0; col <= '0; orow <= '0; pass <= '0;
      min_re <= '0; min_im <= '0;
      acc_main <= '0; acc_corr <= '0;
    end else begin
      case (state)
        S_LOAD: if (in_valid) begin
          if (int'(ld_idx) < MN) begin
            min_re <= (ld_idx == '0 || in_re < min_re) ? in_re : min_re;
            min_im <= (ld_idx == '0 || in_im < min_im) ? in_im : min_im;
          end
          if (ld_idx == LAST_LD) begin
            ld_idx <= '0; row <= '0; col <= '0; pass <= '0;
            state <= S_RUN;
          end else ld_idx <= ld_idx + 1'b1;
        end
        S_RUN: begin
          acc_main <= main_n;
          acc_corr <= corr_n;
          if (col != LAST_COL) col <= col + 1'b1;
          else begin
            col <= '0;
            if (row != LAST_ROW) row <= row + 1'b1;
            else begin
              row <= '0;
              if (pass != 2'd3) pass <= pass + 2'd1;
              else begin
                orow <= '0;
                state <= S_SEND;
              end
            end
          end
        end
        default: if (out_ready) begin
          if (orow == LAST_ROW) state <= S_LOAD;
          else orow <= orow + 1'b1;
        end
      endcase
    end
  end

  AST_LHS_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN) |-> !lhs[AW-1]); // R4
  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid)); // R1
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im))); // R7
  AST_PASS_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && col == LAST_COL && row == LAST_ROW && pass != 2'd3)
      |=> (state == S_RUN && pass == $past(pass) + 2'd1)); // R8
endmodule

// File: tb/test_cplx_offset_mvm.sv
module test_cplx_offset_mvm;
  localparam int M = 4, N = 4, W = 8;
  localparam int DW = W + 1;
  localparam int OW = 2*DW + $clog2(N) + 3;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 0;
  logic signed [DW-1:0] in_re = '0, in_im = '0;
  logic in_ready, out_valid;
  logic signed [OW-1:0] out_re, out_im;

  cplx_offset_mvm #(.M(M), .N(N), .W(W)) i_cplx_offset_mvm (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_ready(out_ready),
    .out_re(out_re), .out_im(out_im));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  int ar [M][N], ai [M][N], br [N], bi [N];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint ref_re(input int r);
    longint s = 0;
    for (int c = 0; c < N; c++) s += longint'(ar[r][c])*br[c] - longint'(ai[r][c])*bi[c];
    return s;
  endfunction

  function automatic longint ref_im(input int r);
    longint s = 0;
    for (int c = 0; c < N; c++) s += longint'(ar[r][c])*bi[c] + longint'(ai[r][c])*br[c];
    return s;
  endfunction

  task automatic beat(input int re, input int im);
    @(negedge clk);
    in_valid = 1; in_re = DW'(re); in_im = DW'(im);
    chk(in_ready === 1'b1, "R1 ready during load", in_ready, 1);
    @(posedge clk);
  endtask

  task automatic run_case(input string name, input bit stall);
    int cnt = 0, row = 0;
    logic signed [OW-1:0] hre, him;
    bit held = 0;
    for (int r = 0; r < M; r++)
      for (int c = 0; c < N; c++) beat(ar[r][c], ai[r][c]);
    for (int c = 0; c < N; c++) beat(br[c], bi[c]);
    @(negedge clk);
    in_valid = 0;
    chk(in_ready === 1'b0, "R1 not ready while computing", in_ready, 0);
    while (out_valid !== 1'b1 && cnt < 1000) begin
      cnt++;
      @(negedge clk);
    end
    chk(cnt == 4*M*N, "R8 latency", cnt, 4*M*N);
    while (row < M && cnt < 3000) begin
      if (held) begin
        chk(out_valid && out_re == hre && out_im == him, "R7 hold under stall", out_re, hre);
        held = 0;
      end
      out_ready = stall ? ($urandom_range(0, 2) != 0) : 1'b1;
      if (out_valid && out_ready) begin
        chk(out_re == ref_re(row), {"R2 real ", name}, out_re, ref_re(row));
        chk(out_im == ref_im(row), {"R3 imag ", name}, out_im, ref_im(row));
        row++;
      end else if (out_valid) begin
        hre = out_re; him = out_im; held = 1;
      end
      cnt++;
      @(negedge clk);
    end
    out_ready = 0;
    chk(in_ready === 1'b1 && out_valid === 1'b0, "R9 back to load", in_ready, 1);
  endtask

  task automatic fill(input int lo, input int hi);
    for (int r = 0; r < M; r++)
      for (int c = 0; c < N; c++) begin
        ar[r][c] = $urandom_range(hi - lo) + lo;
        ai[r][c] = $urandom_range(hi - lo) + lo;
      end
    for (int c = 0; c < N; c++) begin
      br[c] = $urandom_range(hi - lo) + lo;
      bi[c] = $urandom_range(hi - lo) + lo;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(in_ready === 1'b1 && out_valid === 1'b0, "R9 reset state", out_valid, 0);
    fill(-256, -256);
    run_case("R5 all -256 (max lift)", 0);
    fill(255, 255);
    run_case("R5 R6 all 255 (zero lift)", 0);
    fill(0, 255);
    run_case("R6 nonnegative random", 1);
    fill(-256, 255);
    ar[0][0] = -256; ai[M-1][N-1] = 255;
    run_case("R4 mixed extremes", 1);
    for (int t = 0; t < 12; t++) begin
      fill(-256, 255);
      run_case("random signed", t[0]);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule